// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block returns a shared two-wire bus to a clean idle state before the main I2C master is allowed to run. Firmware or a power-up controller raises a start request. The sequencer then clears the master's sticky status bits. It waits a bounded time for any transfer the master still has in flight. It then holds the master in soft reset and takes direct control of the clock and data lines.

While it owns the lines, the block releases both and senses them. If either line reads low, it gives the clock line a slow low/high pulse and senses again. A slave that is stuck mid-byte shifts out its remaining bits this way and lets go of the data line. The number of pulses has a limit. After the pulsing phase, the block places a START and then a STOP on the bus, so every slave's protocol logic returns to idle. Last, it releases the soft reset, waits for the master to settle, and reports completion.

Every delay is a count of pulses on a free-running microsecond tick input. The pad drivers are open-drain: an output of 1 pulls the line low, and an output of 0 releases it. Sensed line values pass through a two-flop synchronizer.

Top module: `i2c_bus_recover`

## Requirements
- R1: While reset is held and afterwards until a start request arrives, all outputs are 0: both lines are released, soft reset is off, busy, clear and done are all low.
- R2: A start_i pulse seen while the block is idle (busy_o and done_o both low) produces exactly one cycle of stat_clr_o on the next cycle. start_i is ignored while a sequence runs, so the sequence gives only one clear pulse and one done pulse.
- R3: xfer_pending_i is sampled at the start of the wait phase and again every POLL_US ticks. The wait ends one interval after the first sample that reads low, or after POLL_TRIES samples in all, whichever comes first.
- R4: soft_rst_o rises when the wait phase ends and stays high through the pulsing phase, the START hold and the STOP hold. It is low during the final settle wait.
- R5: When either synchronized line reads low at a sense point, SCL is pulled low for HALF_US ticks and then released for HALF_US ticks before the next sense point.
- R6: At most PULSE_TRIES clock pulses are given. Pulsing stops at the first sense point where both lines read high.
- R7: A START follows the pulsing phase: SDA is pulled low for HOLD_US ticks while SCL is released.
- R8: A STOP follows the START: both lines are released for HOLD_US ticks with soft reset still high.
- R9: soft_rst_o then falls, and after HOLD_US more ticks done_o is high for exactly one cycle. busy_o is low from that cycle onward.
- R10: Every timed phase advances only on us_tick, so phase lengths scale with the tick period.
- R11: The block pulls a line low only while soft_rst_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| start_i | input | 1 | Request to run a recovery sequence |
| xfer_pending_i | input | 1 | Master still has a transfer in flight |
| scl_i | input | 1 | Sensed clock line level (asynchronous) |
| sda_i | input | 1 | Sensed data line level (asynchronous) |
| scl_oe_o | output | 1 | 1 pulls the clock line low |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| soft_rst_o | output | 1 | Holds the master engine in reset |
| stat_clr_o | output | 1 | One-cycle write-1-to-clear strobe for the master's status bits |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two outcomes can coincide at the last permitted sense point: the stuck slave lets go of SDA, and the pulse limit is reached. The bench models a slave that holds SDA low for an exact number of SCL falling edges. Setting that number equal to PULSE_TRIES makes the two meet. The run passes only if exactly PULSE_TRIES pulses are counted, no extra pulse appears, and the START hold has its full length. A second overlap is a fresh start request that arrives while polling is under way, together with a pending flag that drops in mid-poll. The run passes when the number of poll intervals matches the drop point and there is still only one clear pulse and one done pulse.

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover #(
  parameter int POLL_TRIES  = 10,
  parameter int POLL_US     = 500,
  parameter int PULSE_TRIES = 10,
  parameter int HALF_US     = 100,
  parameter int HOLD_US     = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic start_i,
  input  logic xfer_pending_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic soft_rst_o,
  output logic stat_clr_o,
  output logic busy_o,
  output logic done_o
);

  localparam int MAX_A  = (POLL_US > HALF_US) ? POLL_US : HALF_US;
  localparam int MAX_US = (MAX_A > HOLD_US) ? MAX_A : HOLD_US;
  localparam int TW     = $clog2(MAX_US + 1);
  localparam int PW     = $clog2(POLL_TRIES + 1);
  localparam int CW     = $clog2(PULSE_TRIES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CLR, S_POLL, S_SENSE, S_LOW, S_HIGH,
    S_START, S_STOP, S_SETTLE, S_DONE
  } state_t;

  state_t        state;
  logic [TW-1:0] tmr;
  logic [PW-1:0] poll_n;
  logic [CW-1:0] pulse_n;
  logic          pend_q;
  logic [1:0]    scl_q, sda_q;

  wire expire   = us_tick && (tmr == TW'(1));
  wire lines_hi = scl_q[1] && sda_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 2'b11;
      sda_q <= 2'b11;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      tmr     <= '0;
      poll_n  <= '0;
      pulse_n <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (us_tick && tmr != '0) tmr <= tmr - TW'(1);
      case (state)
        S_IDLE: if (start_i) state <= S_CLR;
        S_CLR: begin
          state  <= S_POLL;
          tmr    <= TW'(POLL_US);
          poll_n <= PW'(1);
          pend_q <= xfer_pending_i;
        end
        S_POLL: if (expire) begin
          if (!pend_q || poll_n == PW'(POLL_TRIES)) begin
            state   <= S_SENSE;
            pulse_n <= '0;
          end else begin
            poll_n <= poll_n + PW'(1);
            pend_q <= xfer_pending_i;
            tmr    <= TW'(POLL_US);
          end
        end
        S_SENSE: begin
          if (lines_hi || pulse_n == CW'(PULSE_TRIES)) begin
            state <= S_START;
            tmr   <= TW'(HOLD_US);
          end else begin
            state <= S_LOW;
            tmr   <= TW'(HALF_US);
          end
        end
        S_LOW: if (expire) begin
          state <= S_HIGH;
          tmr   <= TW'(HALF_US);
        end
        S_HIGH: if (expire) begin
          state   <= S_SENSE;
          pulse_n <= pulse_n + CW'(1);
        end
        S_START: if (expire) begin
          state <= S_STOP;
          tmr   <= TW'(HOLD_US);
        end
        S_STOP: if (expire) begin
          state <= S_SETTLE;
          tmr   <= TW'(HOLD_US);
        end
        S_SETTLE: if (expire) state <= S_DONE;
        S_DONE:   state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  assign scl_oe_o   = (state == S_LOW);
  assign sda_oe_o   = (state == S_START);
  assign soft_rst_o = state inside {S_SENSE, S_LOW, S_HIGH, S_START, S_STOP};
  assign stat_clr_o = (state == S_CLR);
  assign busy_o     = (state != S_IDLE) && (state != S_DONE);
  assign done_o     = (state == S_DONE);

  // R2
  start_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !done_o) |=> stat_clr_o);

  // R2
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr_o |=> !stat_clr_o && busy_o);

  // R3
  poll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_POLL && !us_tick) |=> state == S_POLL);

  // R4
  rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(soft_rst_o) |-> busy_o && !scl_oe_o && !sda_oe_o);

  // R5
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe_o) |-> $past(!(scl_q[1] && sda_q[1])));

  // R6
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_n <= CW'(PULSE_TRIES));

  // R7
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> $past(scl_q[1] && sda_q[1]) || $past(pulse_n) == CW'(PULSE_TRIES));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);

  // R10
  low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe_o && !us_tick) |=> scl_oe_o);

endmodule

// File: tb/i2c_bus_recover_tb.sv
module i2c_bus_recover_tb_top;
  localparam int PT = 10, PU = 20, CT = 10, HU = 5, HD = 30;

  logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b0, start_i = 1'b0, pend = 1'b0;
  logic scl_oe, sda_oe, soft_rst, stat_clr, busy, done;
  int   tick_div = 1, tcnt = 0;
  int   fall_cnt = 0, fall_base = 0, stuck_k = 0;
  int   total = 0, bad = 0;

  wire scl_line = !scl_oe;
  wire sda_line = !sda_oe && ((fall_cnt - fall_base) >= stuck_k);

  i2c_bus_recover #(.POLL_TRIES(PT), .POLL_US(PU), .PULSE_TRIES(CT),
                    .HALF_US(HU), .HOLD_US(HD)) dut_i (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start_i(start_i),
    .xfer_pending_i(pend), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .soft_rst_o(soft_rst),
    .stat_clr_o(stat_clr), .busy_o(busy), .done_o(done));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (tcnt >= tick_div - 1) begin tcnt <= 0; us_tick <= 1'b1; end
    else begin tcnt <= tcnt + 1; us_tick <= 1'b0; end
  end

  always @(negedge scl_line) fall_cnt++;

  logic meas_clr = 1'b0;
  int m_clr, m_pre, m_rst, m_post, m_pulse, m_scl, m_sda, m_rel, m_done, m_bad_drv, m_bad_start;
  bit rst_seen, prev_scl;

  always @(negedge clk) begin
    if (meas_clr) begin
      m_clr = 0; m_pre = 0; m_rst = 0; m_post = 0; m_pulse = 0; m_scl = 0;
      m_sda = 0; m_rel = 0; m_done = 0; m_bad_drv = 0; m_bad_start = 0;
      rst_seen = 0; prev_scl = 0;
    end else begin
      if (stat_clr) m_clr++;
      if (busy && !soft_rst && !rst_seen) m_pre++;
      if (soft_rst) begin m_rst++; rst_seen = 1; end
      if (busy && !soft_rst && rst_seen) m_post++;
      if (scl_oe && !prev_scl) m_pulse++;
      if (scl_oe) m_scl++;
      if (sda_oe) m_sda++;
      if (soft_rst && !scl_oe && !sda_oe) m_rel++;
      if (done) m_done++;
      if ((scl_oe || sda_oe) && !soft_rst) m_bad_drv++;
      if (sda_oe && !scl_line) m_bad_start++;
      prev_scl = scl_oe;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(string req, int act, int lo, int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // mode: 0 no pending, 1 pending throughout, 2 pending drops mid-poll
  task automatic run(int mode, int k, bit extra);
    @(posedge clk); #1;
    meas_clr = 1'b1; stuck_k = k; fall_base = fall_cnt; pend = (mode != 0);
    @(posedge clk); #1 meas_clr = 1'b0;
    repeat (5) @(posedge clk);
    #1 start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
    fork
      begin
        if (mode == 2) begin repeat (2*PU+5) @(posedge clk); #1 pend = 1'b0; end
      end
      begin
        if (extra) begin
          repeat (30) @(posedge clk); #1 start_i = 1'b1;
          @(posedge clk); #1 start_i = 1'b0;
        end
      end
    join
    while (m_done == 0) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  function automatic int rst_len(int p);
    return p*(1+2*HU) + 1 + 2*HD;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R1 outputs during reset", {scl_oe, sda_oe, soft_rst, stat_clr, busy, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 outputs idle after reset", {scl_oe, sda_oe, soft_rst, stat_clr, busy, done}, 0);
  endtask

  task automatic t_clean();
    run(0, 0, 0);
    chk("R2 clear pulse", m_clr, 1);
    chk("R3 poll single interval", m_pre, 1+PU);
    chk("R4 soft reset span", m_rst, rst_len(0));
    chk("R6 no pulses on idle bus", m_pulse, 0);
    chk("R7 start hold", m_sda, HD);
    chk("R7 start with scl high", m_bad_start, 0);
    chk("R8 released under reset", m_rel, 1+HD);
    chk("R9 settle wait", m_post, HD);
    chk("R9 single done", m_done, 1);
    chk("R9 busy low after done", busy, 0);
    chk("R11 drive only in reset", m_bad_drv, 0);
  endtask

  task automatic t_stuck3();
    run(0, 3, 0);
    chk("R5 pulse count", m_pulse, 3);
    chk("R5 scl low time", m_scl, 3*HU);
    chk("R4 soft reset span", m_rst, rst_len(3));
    chk("R8 released under reset", m_rel, 4 + 3*HU + HD);
    chk("R11 drive only in reset", m_bad_drv, 0);
  endtask

  task automatic t_limit();
    run(0, CT, 0);
    chk("R6 release at limit", m_pulse, CT);
    chk("R7 start hold at limit", m_sda, HD);
    run(0, 40, 0);
    chk("R6 give up", m_pulse, CT);
    chk("R4 span on give up", m_rst, rst_len(CT));
  endtask

  task automatic t_pend();
    run(1, 0, 0);
    chk("R3 poll exhausted", m_pre, 1+PT*PU);
    run(2, 0, 1);
    chk("R3 poll drop", m_pre, 1+4*PU);
    chk("R2 start ignored clr", m_clr, 1);
    chk("R2 start ignored done", m_done, 1);
  endtask

  task automatic t_slow();
    tick_div = 3;
    run(0, 2, 0);
    chk_rng("R10 start hold scaled", m_sda, 3*HD-2, 3*HD);
    chk_rng("R10 poll scaled", m_pre, 1+3*PU-2, 1+3*PU);
    chk_rng("R10 scl low scaled", m_scl, 2*(3*HU-2), 2*3*HU);
    chk("R10 pulses", m_pulse, 2);
    tick_div = 1;
  endtask

  initial begin
    meas_clr = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    t_clean();
    t_stuck3();
    t_limit();
    t_pend();
    t_slow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hang expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule